// File: doc/BRIEF.md
# Four-Lane Bit-Interleaving Serializer and Deinterleaver

This block joins four parallel lanes into one serial bit stream and splits a received serial stream back into four lanes. Everything runs on a single clock. The serial side moves one bit per cycle, and each lane moves one bit per four-cycle group. On the transmit side, one bit is taken from each lane in a fixed order. Lane 3 is sent inverted, so that a frame detector at the far end has a fixed polarity reference for working out the lane order.

On the receive side, the deinterleaver collects four serial bits per group and places them into lanes according to a rotation offset. It then restores the polarity of lane 3. A one-cycle rotate request moves the lane assignment by one position. A downstream frame detector can issue rotate requests until its lane lines up; that lane is also driven to a dedicated output.

Two active-low loopback selects are provided for test:
- The line loopback turns the serial input around to the serial output.
- The parallel loopback turns the lane inputs around to the lane outputs.

Top module: `lane_ilv_codec`

## Requirements
- R1: Lanes are numbered 0 to 3. `grp_start_o` is high in the first cycle of every four-cycle group, and the cycles of a group are phases 0..3. The value on `tx_lanes_i` in phase 3 is captured at the end of that cycle. During the next group, `ser_o` (when the line loopback is off) carries captured lane p in phase p.
- R2: On the serial output, lane 3 is inverted and lanes 0 to 2 are sent with true polarity.
- R3: With rotation offset 0, the `ser_i` bit of phase p belongs to lane p. The four lanes of a group appear together on `rx_lanes_o` from the first cycle of the next group, and they hold for that whole group. Lane 3 is inverted back, so a stream built as in R1 and R2 returns the original lanes.
- R4: The `ser_i` bit of phase p goes to lane (p + offset) mod 4. Each accepted rotate adds 1 to the offset modulo 4, so four rotates bring the lane order back to where it started.
- R5: A rotate request (`rotate_i` high for a cycle) takes effect at the end of the current group, and that group is still deinterleaved with the old offset. Any number of requests inside one group count as one. A request in phase 3 applies at that same group boundary.
- R6: `frame_lane_o` always carries receive lane 3 of the deinterleaved word, including while the parallel loopback is on.
- R7: While `line_lb_n_i` is low, `ser_o` equals `ser_i` in the same cycle. Deinterleaving into `rx_lanes_o` continues unchanged.
- R8: While `par_lb_n_i` is low, `rx_lanes_o` equals `tx_lanes_i` in the same cycle. The serial transmit path is unaffected.
- R9: While `rst_n` is low, on each clock edge:
  - the phase counter and the rotation offset clear to 0;
  - the captured transmit word and the receive word clear to 0.
  
  As a result, the first group after reset sends the serial bits 0, 0, 0, 1, and `rx_lanes_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_lanes_i | input | NUM_LANES | Parallel transmit lanes, one bit per lane |
| ser_o | output | 1 | Serial transmit bit |
| ser_i | input | 1 | Serial receive bit |
| rx_lanes_o | output | NUM_LANES | Deinterleaved receive lanes |
| frame_lane_o | output | 1 | Receive lane 3, for the frame detector |
| rotate_i | input | 1 | Request to shift the receive lane assignment by one |
| line_lb_n_i | input | 1 | Serial turn-around select, active low |
| par_lb_n_i | input | 1 | Lane turn-around select, active low |
| grp_start_o | output | 1 | High in phase 0 of each group |

## Verification
The bench builds the block with its default of four lanes, which matches the fixed lane numbering that the requirements use. With this lane count, the bench reaches every rotation offset and the wrap of the offset from 3 back to 0 within a handful of groups. The directed stimulus also covers the phase-3 request window, where a late request must still land at the same boundary. Expected lane words are computed in the bench from the slot formula (p + offset) mod 4, so each offset is checked against a separate restatement of the mapping.

// File: rtl/lane_ilv_pkg.sv
package lane_ilv_pkg;
  // receive slot of a serial bit arriving in phase ph under offset rot
  function automatic int lane_slot(input int ph, input int rot, input int n);
    return (ph + rot) % n;
  endfunction

  // next value of a modulo-n counter
  function automatic int step_mod(input int v, input int n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/lane_ilv_phase.sv
module lane_ilv_phase #(
  parameter int NUM_LANES = 4,
  localparam int PH_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_W-1:0] phase_o,
  output logic            grp_start_o,
  output logic            grp_end_o
);
  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= PH_W'(lane_ilv_pkg::step_mod(int'(ph_q), NUM_LANES));
  end

  assign phase_o     = ph_q;
  assign grp_start_o = (ph_q == '0);
  assign grp_end_o   = (ph_q == PH_W'(NUM_LANES - 1));
endmodule

// File: rtl/lane_ilv_tx.sv
module lane_ilv_tx #(
  parameter int NUM_LANES = 4,
  parameter int REF_LANE  = NUM_LANES - 1,
  localparam int PH_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PH_W-1:0]      phase_i,
  input  logic                 grp_end_i,
  input  logic [NUM_LANES-1:0] lanes_i,
  output logic                 bit_o
);
  logic [NUM_LANES-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         word_q <= '0;
    else if (grp_end_i) word_q <= lanes_i;
  end

  // reference lane leaves the block inverted
  assign bit_o = word_q[phase_i] ^ (phase_i == PH_W'(REF_LANE));
endmodule

// File: rtl/lane_ilv_rx.sv
module lane_ilv_rx #(
  parameter int NUM_LANES = 4,
  parameter int REF_LANE  = NUM_LANES - 1,
  localparam int PH_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PH_W-1:0]      phase_i,
  input  logic                 grp_end_i,
  input  logic                 rot_req_i,
  input  logic                 bit_i,
  output logic [NUM_LANES-1:0] word_o,
  output logic [PH_W-1:0]      rot_o,
  output logic                 rot_apply_o
);
  localparam logic [NUM_LANES-1:0] REF_MASK = NUM_LANES'(1) << REF_LANE;

  logic [NUM_LANES-1:0] col_q, col_nxt, word_q;
  logic [PH_W-1:0]      rot_q, slot;
  logic                 pend_q;

  assign slot = PH_W'(lane_ilv_pkg::lane_slot(int'(phase_i), int'(rot_q), NUM_LANES));

  always_comb begin
    col_nxt       = col_q;
    col_nxt[slot] = bit_i;
  end

  assign rot_apply_o = grp_end_i && (pend_q || rot_req_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q  <= '0;
      word_q <= '0;
      rot_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      col_q  <= col_nxt;
      pend_q <= grp_end_i ? 1'b0 : (pend_q || rot_req_i);
      if (grp_end_i)   word_q <= col_nxt ^ REF_MASK;
      if (rot_apply_o) rot_q  <= PH_W'(lane_ilv_pkg::step_mod(int'(rot_q), NUM_LANES));
    end
  end

  assign word_o = word_q;
  assign rot_o  = rot_q;
endmodule

// File: rtl/lane_ilv_codec.sv
module lane_ilv_codec #(
  parameter int NUM_LANES = 4,
  localparam int PH_W     = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
  localparam int REF_LANE = NUM_LANES - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LANES-1:0] tx_lanes_i,
  output logic                 ser_o,
  input  logic                 ser_i,
  output logic [NUM_LANES-1:0] rx_lanes_o,
  output logic                 frame_lane_o,
  input  logic                 rotate_i,
  input  logic                 line_lb_n_i,
  input  logic                 par_lb_n_i,
  output logic                 grp_start_o
);
  logic [PH_W-1:0]      phase_w, rot_w;
  logic                 grp_start_w, grp_end_w, rot_apply_w, tx_bit_w;
  logic [NUM_LANES-1:0] rx_word_w;

  lane_ilv_phase #(.NUM_LANES(NUM_LANES)) u_phase (
    .clk(clk), .rst_n(rst_n), .phase_o(phase_w),
    .grp_start_o(grp_start_w), .grp_end_o(grp_end_w)
  );

  lane_ilv_tx #(.NUM_LANES(NUM_LANES), .REF_LANE(REF_LANE)) u_tx (
    .clk(clk), .rst_n(rst_n), .phase_i(phase_w), .grp_end_i(grp_end_w),
    .lanes_i(tx_lanes_i), .bit_o(tx_bit_w)
  );

  lane_ilv_rx #(.NUM_LANES(NUM_LANES), .REF_LANE(REF_LANE)) u_rx (
    .clk(clk), .rst_n(rst_n), .phase_i(phase_w), .grp_end_i(grp_end_w),
    .rot_req_i(rotate_i), .bit_i(ser_i), .word_o(rx_word_w),
    .rot_o(rot_w), .rot_apply_o(rot_apply_w)
  );

  assign ser_o        = line_lb_n_i ? tx_bit_w : ser_i;
  assign rx_lanes_o   = par_lb_n_i ? rx_word_w : tx_lanes_i;
  assign frame_lane_o = rx_word_w[REF_LANE];
  assign grp_start_o  = grp_start_w;
endmodule

// File: rtl/lane_ilv_codec_chk.sv
module lane_ilv_codec_chk #(
  parameter int NUM_LANES = 4,
  localparam int PH_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [PH_W-1:0]      phase,
  input logic                 grp_start,
  input logic                 grp_end,
  input logic [PH_W-1:0]      rot,
  input logic                 rot_apply,
  input logic                 rotate,
  input logic                 par_lb_n,
  input logic [NUM_LANES-1:0] par_out,
  input logic                 frame_lane
);
  a_r9_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (phase == '0 && rot == '0));

  a_r1_group_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    grp_end |=> grp_start);

  a_r1_phase_advances: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_end |=> (phase == $past(phase) + PH_W'(1)));

  a_r4_rot_steps: assert property (@(posedge clk) disable iff (!rst_n)
    rot_apply |=> (rot == (($past(rot) == PH_W'(NUM_LANES - 1)) ? PH_W'(0) : $past(rot) + PH_W'(1))));

  a_r5_rot_only_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_end |=> $stable(rot));

  a_r5_late_request_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_end && rotate) |-> rot_apply);

  a_r3_lanes_hold_in_group: assert property (@(posedge clk) disable iff (!rst_n)
    (par_lb_n && !grp_end) |=> (!par_lb_n || $stable(par_out)));

  a_r6_frame_lane_matches: assert property (@(posedge clk) disable iff (!rst_n)
    par_lb_n |-> (frame_lane == par_out[NUM_LANES-1]));
endmodule

bind lane_ilv_codec lane_ilv_codec_chk #(.NUM_LANES(NUM_LANES)) chk_i (
  .clk(clk), .rst_n(rst_n), .phase(phase_w), .grp_start(grp_start_w),
  .grp_end(grp_end_w), .rot(rot_w), .rot_apply(rot_apply_w),
  .rotate(rotate_i), .par_lb_n(par_lb_n_i), .par_out(rx_lanes_o),
  .frame_lane(frame_lane_o)
);

// File: tb/lane_ilv_codec_tb_top.sv
`timescale 1ns/1ps
module lane_ilv_codec_tb_top;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] tx_lanes = '0;
  logic         ser_in = 1'b0;
  logic         rotate = 1'b0;
  logic         line_lb_n = 1'b1;
  logic         par_lb_n = 1'b1;
  logic         ser_out, frame_lane, grp_start;
  logic [N-1:0] rx_lanes;

  int n_chk = 0;
  int n_fail = 0;
  int exp_rot = 0;
  logic [N-1:0] last_rx = '0;

  always #2 clk = ~clk;

  lane_ilv_codec #(.NUM_LANES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_lanes_i(tx_lanes), .ser_o(ser_out),
    .ser_i(ser_in), .rx_lanes_o(rx_lanes), .frame_lane_o(frame_lane),
    .rotate_i(rotate), .line_lb_n_i(line_lb_n), .par_lb_n_i(par_lb_n),
    .grp_start_o(grp_start)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic sync_group();
    while (!grp_start) step();
  endtask

  // expected receive word: bit of phase p lands in lane (p+rot)%N, lane 3 restored
  function automatic logic [N-1:0] rx_expect(input logic [N-1:0] bits, input int rot);
    logic [N-1:0] e;
    e = '0;
    for (int p = 0; p < N; p++) e[(p + rot) % N] = bits[p];
    e[N-1] = ~e[N-1];
    return e;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    chk("R9 rx lanes in reset", int'(rx_lanes), 0);
    rst_n = 1'b1;
    exp_rot = 0;
    last_rx = '0;
    chk("R9 group start after reset", int'(grp_start), 1);
    for (int p = 0; p < N; p++) begin
      chk("R9 first serial group", int'(ser_out), (p == N-1) ? 1 : 0);
      step();
    end
  endtask

  task automatic t_tx_group(input logic [N-1:0] w, input string req);
    sync_group();
    tx_lanes = w;
    repeat (N) step();
    for (int p = 0; p < N; p++) begin
      chk(req, int'(ser_out), int'(w[p] ^ (p == N-1)));
      step();
    end
  endtask

  task automatic t_rx_group(input logic [N-1:0] bits, input string req);
    logic [N-1:0] e;
    sync_group();
    for (int p = 0; p < N; p++) begin
      ser_in = bits[p];
      step();
    end
    e = rx_expect(bits, exp_rot);
    last_rx = e;
    chk(req, int'(rx_lanes), int'(e));
    chk("R6 frame lane", int'(frame_lane), int'(e[N-1]));
  endtask

  task automatic t_rotate_once();
    sync_group();
    rotate = 1'b1; step(); rotate = 1'b0;
    exp_rot = (exp_rot + 1) % N;
    t_rx_group(4'b0010, "R4 single rotate mapping");
  endtask

  task automatic t_rotate_multi();
    sync_group();
    rotate = 1'b1; step(); rotate = 1'b0; step();
    rotate = 1'b1; step(); rotate = 1'b0;
    exp_rot = (exp_rot + 1) % N;
    t_rx_group(4'b0100, "R5 two requests count once");
  endtask

  task automatic t_rotate_late();
    sync_group();
    repeat (N-1) step();
    rotate = 1'b1; step(); rotate = 1'b0;
    exp_rot = (exp_rot + 1) % N;
    t_rx_group(4'b1011, "R5 phase-3 request");
  endtask

  task automatic t_line_loop();
    line_lb_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      ser_in = logic'(i % 3 == 1);
      #1;
      chk("R7 serial turn-around", int'(ser_out), int'(ser_in));
      step();
    end
    t_rx_group(4'b0101, "R7 receive continues in line loopback");
    line_lb_n = 1'b1;
  endtask

  task automatic t_par_loop();
    par_lb_n = 1'b0;
    tx_lanes = 4'b1001;
    #1;
    chk("R8 lane turn-around", int'(rx_lanes), 9);
    chk("R6 frame lane under lane loopback", int'(frame_lane), int'(last_rx[N-1]));
    tx_lanes = 4'b0110;
    #1;
    chk("R8 lane turn-around second", int'(rx_lanes), 6);
    t_tx_group(4'b1100, "R8 serial path during lane loopback");
    par_lb_n = 1'b1;
  endtask

  initial begin
    step();
    t_reset();
    t_tx_group(4'b0000, "R2 all-zero group");
    t_tx_group(4'b1111, "R2 all-one group");
    t_tx_group(4'b1010, "R1 alternating group");
    t_tx_group(4'b0110, "R1 mixed group");
    t_rx_group(4'b0001, "R3 offset 0 lane 0");
    t_rx_group(4'b1000, "R3 offset 0 lane 3");
    t_rx_group(4'b0110, "R3 offset 0 mixed");
    t_rotate_once();
    t_rx_group(4'b1110, "R4 offset 1 second pattern");
    t_rotate_multi();
    t_rotate_late();
    t_rotate_once();
    chk("R4 offset wrapped to 0", exp_rot, 0);
    t_rx_group(4'b0011, "R4 identity after four rotates");
    t_line_loop();
    t_par_loop();
    t_reset();
    t_rx_group(4'b0001, "R9 offset cleared by reset");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (R1..R9 run): actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule